// File: doc/BRIEF.md
# Ping-Pong Integrator Side Sequencer

This block schedules the two integrator sides of a current-integrating converter front end. While one side integrates the sensor current, the other is held by a shared measure/reset/auto-zero engine. The block watches the level of a conversion-select input, and a busy flag from that engine. It decides which side integrates and when a new measurement cycle on a side is requested. It also reports whether the front end is running without gaps (continuous) or has stalled integration to let measurement catch up (non-continuous).

Eight states carry the sequence. There are four continuous states: integrate A; integrate B while A is measured; integrate A while B is measured; integrate B. There are four halted states: finish measuring A and then B; prepare A; prepare B; finish measuring B and then A. Only levels are used, never edges. A HIGH select level asks for side A to integrate and a LOW level asks for side B. The busy flag comes from the engine and may rise one cycle after a start request, so the block treats the request cycle itself as busy.

Top module: `pingpong_int_seq`

## Requirements
- R1: A synchronous reset samples `conv_sel`. HIGH selects the halted finish-A-then-B state and LOW selects the halted finish-B-then-A state. Both integrate enables are 0 and `cont_mode` is 0 in the cycle after reset. With busy clear and the level unchanged, the matching side's enable (A for HIGH, B for LOW) is 1 three cycles after reset is released.
- R2: `int_en_a` and `int_en_b` are never 1 together. `cont_mode` is 1 exactly when one of them is 1.
- R3: In a single-side integrate state, a change of level starts the measurement of the side that was integrating. From integrate-A with `conv_sel` LOW, the next cycle has `int_en_b`=1, `meas_start`=1 and `meas_side`=0. From integrate-B with `conv_sel` HIGH, the next cycle has `int_en_a`=1, `meas_start`=1 and `meas_side`=1. Side encoding: 0 = A, 1 = B.
- R4: In a measure-while-integrating state, the state falls to the single-side integrate state of the integrating side when busy is clear and the level has not changed. No start pulse is issued.
- R5: In a measure-while-integrating state, if busy is clear and the level has changed in that cycle, the block swaps directly. Integrate-B/measure-A with HIGH goes to integrate-A/measure-B with a start on side 1. The mirror case goes with a start on side 0.
- R6: In a measure-while-integrating state, if busy is set and the level has changed, integration halts in the next cycle: both enables are 0 and `cont_mode` is 0. When busy clears, a start pulse is issued for the other side: side 1 after integrate-B/measure-A, side 0 after integrate-A/measure-B. When busy clears again, the block moves to the prepare state of the side the level selects.
- R7: A prepare state keeps integration halted until busy is clear and `conv_sel` is at that side's level (HIGH for A, LOW for B). It then enters that side's single-side integrate state.
- R8: In the cycle that carries `meas_start`, `meas_busy` is treated as set. An engine that raises busy one cycle after the request is therefore never seen as done early.
- R9: `meas_start` is never 1 in two consecutive cycles. `meas_side` is meaningful only while `meas_start` is 1.
- R10: While a single-side integrate state keeps seeing its own level, the block stays in that state with no start pulse, however long the level is held.
- R11: Under arbitrary sequences of select levels and engine latencies, every cycle's outputs follow the transition rules R1 to R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; samples `conv_sel` to choose the start state |
| conv_sel | input | 1 | Conversion-select level: HIGH asks for side A integration, LOW for side B |
| meas_busy | input | 1 | Set by the measure/reset/auto-zero engine for the whole of a cycle |
| int_en_a | output | 1 | Integrate enable, side A |
| int_en_b | output | 1 | Integrate enable, side B |
| meas_start | output | 1 | One-cycle request for a new measure/reset/auto-zero cycle |
| meas_side | output | 1 | Side of the request: 0 = A, 1 = B |
| cont_mode | output | 1 | 1 in continuous states, 0 while integration is halted |

## Verification
A busy-timer stand-in for the engine raises busy the cycle after each request and holds it for a chosen latency. A bench model of the eight states predicts every output in every cycle. Directed cases cover several patterns. Power-up at each level shows that the initial state follows the sampled level. A long held level tells level sensing from edge sensing. A level change in the exact cycle busy falls separates the direct swap from the fall to single-side integration. A level change while busy is still set must produce the stall with its deferred second-side request. A wrong level during the prepare state shows that integration stays halted. Randomly toggled levels with random engine latencies then mix short and long measurements. These runs separate continuous operation from stalls, and show whether the busy mask in the request cycle is present.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {
    ST_FIN_AB  = 3'd0,
    ST_PREP_A  = 3'd1,
    ST_INT_A   = 3'd2,
    ST_INTB_MA = 3'd3,
    ST_INTA_MB = 3'd4,
    ST_INT_B   = 3'd5,
    ST_PREP_B  = 3'd6,
    ST_FIN_BA  = 3'd7
  } pps_state_t;

  localparam logic SIDE_A = 1'b0;
  localparam logic SIDE_B = 1'b1;
endpackage

// File: rtl/pps_next.sv
module pps_next
  import pps_pkg::*;
(
  input  pps_state_t st,
  input  logic       pend,
  input  logic       sel_hi,
  input  logic       busy_eff,
  input  logic       side_q,
  output pps_state_t st_n,
  output logic       pend_n,
  output logic       start_n,
  output logic       side_n
);
  always_comb begin
    st_n    = st;
    pend_n  = pend;
    start_n = 1'b0;
    side_n  = side_q;
    unique case (st)
      ST_INT_A: begin
        if (!sel_hi) begin
          st_n = ST_INTB_MA; start_n = 1'b1; side_n = SIDE_A;
        end
      end
      ST_INT_B: begin
        if (sel_hi) begin
          st_n = ST_INTA_MB; start_n = 1'b1; side_n = SIDE_B;
        end
      end
      ST_INTB_MA: begin
        if (sel_hi) begin
          if (busy_eff) begin
            st_n = ST_FIN_AB; pend_n = 1'b1;
          end else begin
            st_n = ST_INTA_MB; start_n = 1'b1; side_n = SIDE_B;
          end
        end else if (!busy_eff) begin
          st_n = ST_INT_B;
        end
      end
      ST_INTA_MB: begin
        if (!sel_hi) begin
          if (busy_eff) begin
            st_n = ST_FIN_BA; pend_n = 1'b1;
          end else begin
            st_n = ST_INTB_MA; start_n = 1'b1; side_n = SIDE_A;
          end
        end else if (!busy_eff) begin
          st_n = ST_INT_A;
        end
      end
      ST_FIN_AB: begin
        if (!busy_eff) begin
          if (pend) begin
            pend_n = 1'b0; start_n = 1'b1; side_n = SIDE_B;
          end else begin
            st_n = ST_PREP_A;
          end
        end
      end
      ST_FIN_BA: begin
        if (!busy_eff) begin
          if (pend) begin
            pend_n = 1'b0; start_n = 1'b1; side_n = SIDE_A;
          end else begin
            st_n = ST_PREP_B;
          end
        end
      end
      ST_PREP_A: begin
        if (!busy_eff && sel_hi) st_n = ST_INT_A;
      end
      ST_PREP_B: begin
        if (!busy_eff && !sel_hi) st_n = ST_INT_B;
      end
      default: st_n = st;
    endcase
  end
endmodule

// File: rtl/pps_decode.sv
module pps_decode
  import pps_pkg::*;
(
  input  pps_state_t st,
  output logic       en_a,
  output logic       en_b,
  output logic       cont
);
  always_comb begin
    en_a = 1'b0;
    en_b = 1'b0;
    cont = 1'b0;
    unique case (st)
      ST_INT_A, ST_INTA_MB: begin en_a = 1'b1; cont = 1'b1; end
      ST_INT_B, ST_INTB_MA: begin en_b = 1'b1; cont = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/pingpong_int_seq.sv
module pingpong_int_seq
  import pps_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic conv_sel,
  input  logic meas_busy,
  output logic int_en_a,
  output logic int_en_b,
  output logic meas_start,
  output logic meas_side,
  output logic cont_mode
);
  pps_state_t st_q, st_n;
  logic pend_q, pend_n, start_n, side_n, side_q;
  logic busy_eff;

  // The engine may raise busy one cycle after the request: mask that gap.
  assign busy_eff = meas_busy | meas_start;

  pps_next u_next (
    .st       (st_q),
    .pend     (pend_q),
    .sel_hi   (conv_sel),
    .busy_eff (busy_eff),
    .side_q   (side_q),
    .st_n     (st_n),
    .pend_n   (pend_n),
    .start_n  (start_n),
    .side_n   (side_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= conv_sel ? ST_FIN_AB : ST_FIN_BA;
      pend_q     <= 1'b0;
      meas_start <= 1'b0;
      side_q     <= SIDE_A;
    end else begin
      st_q       <= st_n;
      pend_q     <= pend_n;
      meas_start <= start_n;
      side_q     <= side_n;
    end
  end

  assign meas_side = side_q;

  pps_decode u_dec (
    .st   (st_q),
    .en_a (int_en_a),
    .en_b (int_en_b),
    .cont (cont_mode)
  );

  AST_RESET_HALT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!int_en_a && !int_en_b && !cont_mode)); // R1

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
    !(int_en_a && int_en_b) && (cont_mode == (int_en_a || int_en_b))); // R2

  AST_SWITCH_TO_B: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_INT_A && !conv_sel) |=> (int_en_b && meas_start && !meas_side)); // R3

  AST_SWITCH_TO_A: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_INT_B && conv_sel) |=> (int_en_a && meas_start && meas_side)); // R3

  AST_STALL_HALT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_INTB_MA && conv_sel && meas_busy) |=> (!int_en_a && !int_en_b && !cont_mode)); // R6

  AST_PREP_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PREP_A && !conv_sel) |=> (!int_en_a && !int_en_b)); // R7

  AST_START_MASK: assert property (@(posedge clk) disable iff (rst)
    (meas_start && st_q == ST_INTB_MA && !conv_sel) |=> (st_q == ST_INTB_MA)); // R8

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    meas_start |=> !meas_start); // R9

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_INT_A && conv_sel) |=> (int_en_a && !meas_start)); // R10
endmodule

// File: tb/pingpong_int_seq_tb.sv
`timescale 1ns/1ps
module pingpong_int_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_sel = 1'b1;
  logic meas_busy;
  logic int_en_a, int_en_b, meas_start, meas_side, cont_mode;

  int total = 0;
  int bad = 0;
  int lat = 3;
  int cnt = 0;
  string tag = "R1";

  // bench model: 1 finAB,2 prepA,3 intA,4 intB/measA,5 intA/measB,6 intB,7 prepB,8 finBA
  int   m_st = 1;
  logic m_pend = 1'b0, m_start = 1'b0, m_side = 1'b0;

  always #4 clk = ~clk;

  pingpong_int_seq u_dut (
    .clk(clk), .rst(rst), .conv_sel(conv_sel), .meas_busy(meas_busy),
    .int_en_a(int_en_a), .int_en_b(int_en_b), .meas_start(meas_start),
    .meas_side(meas_side), .cont_mode(cont_mode)
  );

  // engine stand-in: busy from the cycle after a request, for lat cycles
  always_ff @(posedge clk) begin
    if (rst) cnt <= 0;
    else if (meas_start) cnt <= lat;
    else if (cnt != 0) cnt <= cnt - 1;
  end
  assign meas_busy = (cnt != 0);

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", t, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_out(input int s, input logic st);
    exp_out = {(s == 3 || s == 5), (s == 4 || s == 6), (s >= 3 && s <= 6), st};
  endfunction

  task automatic tick();
    int ns; logic np, nst, nsd, eb;
    ns = m_st; np = m_pend; nst = 1'b0; nsd = m_side;
    eb = meas_busy | m_start;
    if (rst) begin
      ns = conv_sel ? 1 : 8; np = 1'b0; nsd = 1'b0;
    end else begin
      case (m_st)
        3: if (!conv_sel) begin ns = 4; nst = 1; nsd = 0; end
        6: if (conv_sel) begin ns = 5; nst = 1; nsd = 1; end
        4: if (conv_sel) begin
             if (eb) begin ns = 1; np = 1; end else begin ns = 5; nst = 1; nsd = 1; end
           end else if (!eb) ns = 6;
        5: if (!conv_sel) begin
             if (eb) begin ns = 8; np = 1; end else begin ns = 4; nst = 1; nsd = 0; end
           end else if (!eb) ns = 3;
        1: if (!eb) begin
             if (m_pend) begin np = 0; nst = 1; nsd = 1; end else ns = 2;
           end
        8: if (!eb) begin
             if (m_pend) begin np = 0; nst = 1; nsd = 0; end else ns = 7;
           end
        2: if (!eb && conv_sel) ns = 3;
        7: if (!eb && !conv_sel) ns = 6;
        default: ;
      endcase
    end
    @(posedge clk);
    m_st = ns; m_pend = np; m_start = nst; m_side = nsd;
    #2;
    chk(tag, {4'd0, int_en_a, int_en_b, cont_mode, meas_start}, {4'd0, exp_out(m_st, m_start)});
    if (m_start) chk(tag, {7'd0, meas_side}, {7'd0, m_side});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && meas_busy; i++) tick();
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    // R1: power-up with HIGH level
    tag = "R1"; rst = 1; conv_sel = 1; tick(); rst = 0;
    chk("R1", {5'd0, int_en_a, int_en_b, cont_mode}, 8'd0);
    tick(); tick(); tick();
    chk("R1", {6'd0, int_en_a, int_en_b}, 8'h2);
    // R1: power-up with LOW level
    rst = 1; conv_sel = 0; #2; tick(); rst = 0;
    tick(); tick(); tick();
    chk("R1", {6'd0, int_en_a, int_en_b}, 8'h1);
    // R10: long held level in integrate-B
    tag = "R10";
    for (int i = 0; i < 20; i++) tick();
    chk("R10", {7'd0, int_en_b}, 8'h1);
    // R3: B -> A swap with start on side B
    tag = "R3"; conv_sel = 1; tick();
    chk("R3", {5'd0, int_en_a, meas_start, meas_side}, 8'h7);
    // R8: request cycle is masked
    tag = "R8"; tick();
    chk("R8", {7'd0, int_en_a}, 8'h1);
    // R4: busy clears, level kept
    tag = "R4"; wait_idle(); tick();
    chk("R4", {6'd0, int_en_a, meas_start}, 8'h2);
    // R3: A -> B with start on side A
    tag = "R3"; conv_sel = 0; tick();
    chk("R3", {5'd0, int_en_b, meas_start, meas_side}, 8'h6);
    tag = "R4"; tick(); wait_idle(); tick();
    // R5: level change exactly as busy falls
    tag = "R5"; conv_sel = 1; tick(); tick(); wait_idle();
    conv_sel = 0; tick();
    chk("R5", {5'd0, int_en_b, meas_start, meas_side}, 8'h6);
    tick(); wait_idle(); tick();
    // R6: change while busy -> stall with deferred second request
    tag = "R6"; lat = 6; conv_sel = 1; tick(); tick(); tick();
    conv_sel = 0; tick();
    chk("R6", {5'd0, int_en_a, int_en_b, cont_mode}, 8'd0);
    for (int i = 0; i < 40 && !meas_start; i++) tick();
    chk("R6", {6'd0, meas_start, meas_side}, 8'h2);
    // R7: prepare state waits for its level
    tag = "R7"; conv_sel = 1; tick(); wait_idle();
    for (int i = 0; i < 5; i++) tick();
    chk("R7", {6'd0, int_en_a, int_en_b}, 8'd0);
    conv_sel = 0; tick();
    chk("R7", {6'd0, int_en_a, int_en_b}, 8'h1);
    // R11: random levels and latencies
    tag = "R11";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 6 == 0) conv_sel = ~conv_sel;
      if ($urandom % 10 == 0) lat = 1 + ($urandom % 8);
      tick();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule